// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of one rank of single-data-rate SDRAM with four internal banks. Once reset is released, it brings the memory out of power-up. It first holds the clock-enable pin low, then raises it and waits out a long stabilisation interval. After that it precharges every bank, issues a run of auto-refresh commands and writes the mode register. The word it writes to the mode register is assembled from parameter fields and one CAS-latency select input.

When the post-load-mode delay has elapsed, the block raises `ready` and switches to maintenance. A countdown reloads from the `refresh_reload` input. Each time the countdown reaches zero, the block issues a precharge-all followed by an auto-refresh, and `ready` stays high throughout. Each command-to-command gap has its own parameter. Every cycle in which no command is due drives NOP. An integrating controller would normally set `refresh_reload` to the refresh period in clocks minus a fixed margin of 20 (for example 1292 or 1539).

Top module: `sdr_seq_top`

## Requirements
- R1: `cke` is low while reset is applied and in the first cycle after reset is released. It then goes high and stays high until the next reset.
- R2: The first command is precharge-all. It is encoded {cs_n,ras_n,cas_n,we_n}=0010 with `addr[10]` high, and it is issued exactly STARTUP_CYC cycles after the cycle in which `cke` first reads high.
- R3: Exactly INIT_REFS (default 8) auto-refresh commands (0001) follow. The first comes T_RP (default 2) cycles after the precharge, and each of the others comes T_RC (default 7) cycles after the previous one.
- R4: Load-mode (0000) is issued T_RC cycles after the last initial refresh, with the mode word on `addr`. The word uses bits 2:0 for burst length (1=000, 2=001, 4=010, 8=100), bit 3 for burst type (1 = interleaved), bits 6:4 for CAS latency, and bit 9 high for single-location write bursts. All other bits are zero. The defaults give burst length 1, sequential order and single writes.
- R5: `ready` is low until exactly T_MRD (default 2) cycles after the load-mode command and goes high in that cycle.
- R6: Every cycle that carries none of the commands above drives NOP (0111).
- R7: Once `ready` is high, a precharge-all is issued every `refresh_reload`+1 cycles. The first one comes `refresh_reload`+1 cycles after `ready` rises. Each is followed T_RP cycles later by an auto-refresh, and `ready` never drops.
- R8: Asserting `rst_n` at any time forces `cke` low, `ready` low and NOP on the command pins. Releasing it restarts the whole power-up sequence.
- R9: `cas_lat3` selects the CAS-latency field: 0 gives latency 2 (010), 1 gives latency 3 (011). With the other defaults the word is 0x220 or 0x230.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects latency 2 |
| refresh_reload | input | RELOAD_W | Refresh countdown reload value, in clocks |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address (always zero for these commands) |
| addr | output | ADDR_W | Address bus: A10 for precharge-all, mode word for load-mode |
| ready | output | 1 | High once initialisation has completed |

## Verification
The power-up run is first observed with latency 2 selected and a reload of 300, and then again after a reset asserted in the middle of refresh operation, this time with latency 3 and a reload of 150. The two mode words separate the CAS-latency field from the fixed fields. The restart shows that reset really rewinds the sequence rather than resuming it. Two different reload values separate a correct interval of reload+1 from an off-by-one error or a hard-wired period. Every non-NOP command is logged with its cycle number, so both the command order and each gap are measured exactly.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWR,       // CKE low, load stabilisation timer
    ST_STABLE,    // CKE high, waiting
    ST_PRE,       // init precharge-all
    ST_WAIT_RP,
    ST_REF,       // init auto-refresh
    ST_WAIT_RC,
    ST_MRS,       // load mode register
    ST_WAIT_MRD,
    ST_IDLE,      // ready, waiting for refresh due
    ST_RPRE,      // maintenance precharge-all
    ST_RWAIT_RP,
    ST_RREF,      // maintenance auto-refresh
    ST_RWAIT_RC
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("reset synchroniser needs two stages");
  end
endmodule

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_val;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // Once expired, the timer stays expired until reloaded (gaps never shrink: R6)
  assert_timer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int W            = 12,
  parameter int BURST_LEN    = 1,
  parameter bit INTERLEAVED  = 1'b0,
  parameter bit SINGLE_WRITE = 1'b1
) (
  input  logic         cas3,
  output logic [W-1:0] word
);
  localparam logic [2:0] BL_CODE = (BURST_LEN == 8) ? 3'b100 :
                                   (BURST_LEN == 4) ? 3'b010 :
                                   (BURST_LEN == 2) ? 3'b001 : 3'b000;

  logic [2:0] cl_field;
  assign cl_field = cas3 ? 3'b011 : 3'b010;

  always_comb begin
    word      = '0;
    word[2:0] = BL_CODE;
    word[3]   = INTERLEAVED;
    word[6:4] = cl_field;
    word[9]   = SINGLE_WRITE;
  end

  initial begin
    assert (W >= 10) else $error("address bus too narrow for mode word");
  end
endmodule

// File: rtl/sdr_refresh_tick.sv
module sdr_refresh_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         due
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en || cnt_q == '0) cnt_d = reload;
    else                    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign due = en && (cnt_q == '0);

  // A due pulse is followed by a fresh full interval (R7)
  assert_due_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (due && reload != '0) |=> !due);
endmodule

// File: rtl/sdr_seq_top.sv
module sdr_seq_top #(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int RELOAD_W     = 16,
  parameter int STARTUP_CYC  = 15000,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 8,
  parameter int BURST_LEN    = 1,
  parameter bit INTERLEAVED  = 1'b0,
  parameter bit SINGLE_WRITE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cas_lat3,
  input  logic [RELOAD_W-1:0] refresh_reload,
  output logic                cke,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [BA_W-1:0]     ba,
  output logic [ADDR_W-1:0]   addr,
  output logic                ready
);
  import sdr_seq_pkg::*;

  localparam int MAX_GAP = (STARTUP_CYC > T_RC) ? STARTUP_CYC : T_RC;
  localparam int TW      = $clog2(MAX_GAP + 1);
  localparam int RCW     = $clog2(INIT_REFS + 1);
  localparam int A10_BIT = 10;

  logic rst_n_s;
  sdr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  seq_state_t        state_q, state_d;
  logic [RCW-1:0]    refs_q, refs_d;
  logic              rdy_q, rdy_d;
  logic              pend_q, pend_d;
  logic              tmr_load, tmr_done, due;
  logic [TW-1:0]     tmr_val;
  logic [ADDR_W-1:0] mode_word;
  logic [3:0]        cmd;

  sdr_gap_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

  sdr_mode_word #(.W(ADDR_W), .BURST_LEN(BURST_LEN), .INTERLEAVED(INTERLEAVED),
                  .SINGLE_WRITE(SINGLE_WRITE)) u_mode (
    .cas3(cas_lat3), .word(mode_word));

  sdr_refresh_tick #(.W(RELOAD_W)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .en(rdy_q), .reload(refresh_reload), .due(due));

  // Timer load per command state: gap counted from the command cycle
  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = '0;
    unique case (state_q)
      ST_PWR:          tmr_val = TW'(STARTUP_CYC - 1);
      ST_PRE, ST_RPRE: tmr_val = TW'(T_RP - 2);
      ST_REF, ST_RREF: tmr_val = TW'(T_RC - 2);
      ST_MRS:          tmr_val = TW'(T_MRD - 2);
      default:         tmr_load = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    refs_d  = refs_q;
    rdy_d   = rdy_q;
    pend_d  = due || (pend_q && state_q != ST_RPRE);
    unique case (state_q)
      ST_PWR:      begin refs_d = '0; state_d = ST_STABLE; end
      ST_STABLE:   if (tmr_done) state_d = ST_PRE;
      ST_PRE:      state_d = ST_WAIT_RP;
      ST_WAIT_RP:  if (tmr_done) state_d = ST_REF;
      ST_REF:      begin refs_d = refs_q + 1'b1; state_d = ST_WAIT_RC; end
      ST_WAIT_RC:  if (tmr_done) state_d = (refs_q == RCW'(INIT_REFS)) ? ST_MRS : ST_REF;
      ST_MRS:      state_d = ST_WAIT_MRD;
      ST_WAIT_MRD: if (tmr_done) begin rdy_d = 1'b1; state_d = ST_IDLE; end
      ST_IDLE:     if (due || pend_q) state_d = ST_RPRE;
      ST_RPRE:     state_d = ST_RWAIT_RP;
      ST_RWAIT_RP: if (tmr_done) state_d = ST_RREF;
      ST_RREF:     state_d = ST_RWAIT_RC;
      ST_RWAIT_RC: if (tmr_done) state_d = ST_IDLE;
      default:     state_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_PWR;
      refs_q  <= '0;
      rdy_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      refs_q  <= refs_d;
      rdy_q   <= rdy_d;
      pend_q  <= pend_d;
    end
  end

  // Output decode from state register
  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    unique case (state_q)
      ST_PRE, ST_RPRE: begin cmd = CMD_PRE; addr[A10_BIT] = 1'b1; end
      ST_REF, ST_RREF: cmd = CMD_REF;
      ST_MRS:          begin cmd = CMD_MRS; addr = mode_word; end
      default:         cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke   = (state_q != ST_PWR);
  assign ba    = '0;
  assign ready = rdy_q;

  initial begin
    assert (T_RP >= 2 && T_RC >= 2 && T_MRD >= 2 && STARTUP_CYC >= 2)
      else $error("command gaps must be at least two cycles");
  end

  assert_cke_hold_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    cke |=> cke);
  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_PRE) |-> addr[A10_BIT]);
  assert_nop_after_pre_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_PRE) |=> (cmd == CMD_NOP));
  assert_ready_cke_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ready |-> cke);
  assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ready |=> ready);
endmodule

// File: tb/sim_sdr_seq_top.sv
module sim_sdr_seq_top;
  localparam int STARTUP = 15000;
  localparam int TRP = 2, TRC = 7, TMRD = 2, NREF = 8;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n, cas_lat3;
  logic [15:0] refresh_reload;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [3:0] cmd;

  int errors = 0, checks = 0, cyc_g = 0, ready_cyc = 0;

  always #10 clk = ~clk; // 50 MHz
  always @(posedge clk) cyc_g <= cyc_g + 1;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  sdr_seq_top #(.STARTUP_CYC(STARTUP), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
                .INIT_REFS(NREF)) u0 (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .refresh_reload(refresh_reload),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .ready(ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state(input string tag);
    @(negedge clk);
    chk(cke == 1'b0, {tag, " R1 cke low in reset"}, int'(cke), 0);
    chk(cmd == NOP, {tag, " R8 NOP in reset"}, int'(cmd), int'(NOP));
    chk(ready == 1'b0, {tag, " R8 ready low in reset"}, int'(ready), 0);
  endtask

  task automatic t_init(input int exp_word, input string tag);
    int cke_rise = -1, pre_at = -1, nref = 0, last_ref = -1, mrs_at = -1, rdy_at = -1;
    int bad = 0, cke_drop = 0, gap_err = 0, first_gap = -1, mw = -1;
    for (int i = 0; i < STARTUP + 500; i++) begin
      @(negedge clk);
      if (cke && cke_rise < 0) cke_rise = cyc_g;
      if (!cke && cke_rise >= 0) cke_drop++;
      if (cmd != NOP) begin
        if (cmd == PRE && pre_at < 0 && addr[10]) pre_at = cyc_g;
        else if (cmd == REF && pre_at >= 0 && mrs_at < 0) begin
          if (nref == 0) first_gap = cyc_g - pre_at;
          else if (cyc_g - last_ref != TRC) gap_err++;
          nref++;
          last_ref = cyc_g;
        end else if (cmd == MRS && mrs_at < 0) begin
          mrs_at = cyc_g;
          mw = int'(addr);
        end else bad++;
      end
      if (ready) begin rdy_at = cyc_g; break; end
    end
    ready_cyc = rdy_at;
    chk(cke_rise >= 0 && cke_drop == 0, {tag, " R1 cke rises and holds"}, cke_drop, 0);
    chk(pre_at - cke_rise == STARTUP, {tag, " R2 precharge after stabilisation"},
        pre_at - cke_rise, STARTUP);
    chk(first_gap == TRP, {tag, " R3 first refresh after precharge"}, first_gap, TRP);
    chk(nref == NREF, {tag, " R3 refresh count"}, nref, NREF);
    chk(gap_err == 0, {tag, " R3 refresh spacing"}, gap_err, 0);
    chk(mrs_at - last_ref == TRC, {tag, " R4 load-mode after last refresh"},
        mrs_at - last_ref, TRC);
    chk(mw == exp_word, {tag, " R4 R9 mode word"}, mw, exp_word);
    chk(rdy_at >= 0 && rdy_at - mrs_at == TMRD, {tag, " R5 ready timing"},
        rdy_at - mrs_at, TMRD);
    chk(bad == 0, {tag, " R6 no stray commands"}, bad, 0);
  endtask

  task automatic t_refresh(input int rl, input int n, input string tag);
    int last_pre = ready_cyc, pres = 0, pend_ref = -1, bad = 0, drop = 0;
    int lim = n * (rl + 1) + 50;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!ready) drop++;
      if (cmd == PRE) begin
        chk(cyc_g - last_pre == rl + 1, {tag, " R7 refresh interval"},
            cyc_g - last_pre, rl + 1);
        chk(addr[10] == 1'b1, {tag, " R7 precharge-all A10"}, int'(addr[10]), 1);
        last_pre = cyc_g;
        pend_ref = cyc_g;
        pres++;
      end else if (cmd == REF) begin
        chk(pend_ref >= 0 && cyc_g - pend_ref == TRP, {tag, " R7 refresh after precharge"},
            cyc_g - pend_ref, TRP);
        pend_ref = -1;
      end else if (cmd != NOP) bad++;
      if (pres == n && pend_ref < 0) break;
    end
    chk(pres == n, {tag, " R7 refresh count"}, pres, n);
    chk(drop == 0, {tag, " R7 ready stays high"}, drop, 0);
    chk(bad == 0, {tag, " R6 no stray commands"}, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cas_lat3 = 1'b0;
    refresh_reload = 16'd300;
    repeat (4) @(negedge clk);
    t_reset_state("power-on");
    rst_n = 1'b1;
    t_init(32'h220, "cl2");
    t_refresh(300, 3, "cl2");
    // mid-run reset, restart with latency 3 and a shorter interval (R8, R9)
    @(negedge clk);
    rst_n = 1'b0;
    cas_lat3 = 1'b1;
    refresh_reload = 16'd150;
    repeat (2) @(negedge clk);
    t_reset_state("restart");
    rst_n = 1'b1;
    t_init(32'h230, "cl3");
    t_refresh(150, 2, "cl3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule